// File: doc/BRIEF.md
# Storage Key Protection Checker

This block keeps a seven-bit protection key for every 4 KB block of a 1 MB physical memory and decides, one request at a time, whether a storage access may proceed. A request carries the absolute byte address, whether it is a fetch or a store, a 4-bit access key, the class of requester (processor operand, processor instruction fetch, channel program, or measurement-block update), and the two override controls together with the translation and private-space qualifiers that limit the low-address override.

An accepted request is registered. In the next cycle the decision is formed combinationally from that registered request and the stored key, and `rspValid` is high for that one cycle only. A denied access raises one violation flag chosen by the requester class. A permitted access sets the block's reference bit and, for a store, its change bit, at the end of that same response cycle. A separate key port writes a whole key and reads any key combinationally. A key write takes precedence over request acceptance and over bookkeeping on the same block.

Top module: `stor_key_guard`

## Requirements
- R1: After reset every key reads as 0 through `keyRdData`, `rspValid` is low and `reqReady` is high.
- R2: `reqReady` is low exactly in cycles where `keyWrEn` is high. A request with `reqValid` and `reqReady` both high gives `rspValid` high for exactly the following cycle. No other cycle has `rspValid` high.
- R3: A checked access is permitted when the access key equals the block's 4-bit access-control value, or when the access key is 0.
- R4: When the block's fetch-protect bit is 0, a fetch is permitted with any key and only stores are checked. When it is 1, fetches and stores are both checked.
- R5: With `reqOvrStor` high, a block whose access-control value is 9 permits any access of class 0 (operand) or class 1 (instruction fetch). The override has no effect for class 2 (channel) or class 3 (measurement).
- R6: With `reqOvrFetch` high, a fetch to an address below 2048 is permitted regardless of key. This does not apply when `reqTranslated` and `reqPrivate` are both high, and it does not apply to class 3.
- R7: On a denied response exactly one flag is high: `rspOpExc` for class 0, `rspIfetchSup` for class 1, `rspChanChk` for class 2, `rspMeasChk` for class 3. On a permitted response no flag is high.
- R8: A permitted access sets the reference bit (key bit 1). A permitted store also sets the change bit (key bit 0). A denied access leaves all key bits unchanged.
- R9: Key layout is {access-control[6:3], fetch-protect[2], reference[1], change[0]}. `keyWrEn` replaces all seven bits of block `keyAddr` at the clock edge. `keyRdData` shows block `keyAddr` combinationally. A key write wins over a reference/change update to the same block in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqAddr | input | 20 | Absolute byte address |
| reqStore | input | 1 | 1 = store, 0 = fetch |
| reqKey | input | 4 | Access key |
| reqClass | input | 2 | 0 operand, 1 instruction fetch, 2 channel, 3 measurement |
| reqOvrStor | input | 1 | Key-9 override control |
| reqOvrFetch | input | 1 | Low-address fetch override control |
| reqTranslated | input | 1 | Address came through translation |
| reqPrivate | input | 1 | Private-space flag of the translation |
| rspValid | output | 1 | Decision valid this cycle |
| rspPermit | output | 1 | Access permitted |
| rspOpExc | output | 1 | Operand protection exception |
| rspIfetchSup | output | 1 | Instruction fetch suppressed |
| rspChanChk | output | 1 | Channel protection check |
| rspMeasChk | output | 1 | Measurement-block protection check |
| keyWrEn | input | 1 | Write a key |
| keyAddr | input | 8 | Block index for key write and read |
| keyWrData | input | 7 | Key value to write |
| keyRdData | output | 7 | Key of block `keyAddr` |

## Verification
Two things can happen in the same cycle: a key write through the key port, and the reference/change update of a permitted access whose response is out in that cycle. The bench provokes this by accepting a permitted store to a block and, in its response cycle, writing a fresh key with clear reference and change bits to that block while another request is offered. The read-back must show exactly the written key, and the request offered during the write must not be accepted. The main sweep covers every access-control value, fetch-protect setting, access key, direction, class and key-9 override, and a second sweep walks the low-address boundary against every qualifier.

// File: rtl/skg_pkg.sv
package skg_pkg;
  typedef struct packed {
    logic [3:0] acc;
    logic       fetchProt;
    logic       refd;
    logic       chg;
  } skg_key_t;

  typedef enum logic [1:0] {
    CLS_OPER   = 2'd0,
    CLS_IFETCH = 2'd1,
    CLS_CHAN   = 2'd2,
    CLS_MEAS   = 2'd3
  } skg_class_t;

  typedef struct packed {
    logic touch;
    logic dirty;
  } skg_upd_t;

  localparam logic [3:0] BYPASS_ACC = 4'd9;
endpackage

// File: rtl/skg_keyarray.sv
module skg_keyarray
  import skg_pkg::*;
#(
  parameter int BLK_CNT = 256,
  localparam int BLK_W = $clog2(BLK_CNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             keyWrEn,
  input  logic [BLK_W-1:0] keyAddr,
  input  skg_key_t         keyWrData,
  output skg_key_t         keyRdData,
  input  logic [BLK_W-1:0] lookupBlk,
  output skg_key_t         lookupKey,
  input  skg_upd_t         upd
);
  skg_key_t keyMem [BLK_CNT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < BLK_CNT; i++) begin
      if (!rstN) begin
        keyMem[i] <= '0;
      end else if (keyWrEn && keyAddr == BLK_W'(i)) begin
        keyMem[i] <= keyWrData;
      end else if (upd.touch && lookupBlk == BLK_W'(i)) begin
        keyMem[i].refd <= 1'b1;
        if (upd.dirty) keyMem[i].chg <= 1'b1;
      end
    end
  end

  assign keyRdData = keyMem[keyAddr];
  assign lookupKey = keyMem[lookupBlk];
endmodule

// File: rtl/skg_ctrl.sv
module skg_ctrl
  import skg_pkg::*;
#(
  parameter int BLK_W     = 8,
  parameter int PAGE_LOG2 = 12,
  parameter int LOW_LIMIT = 2048,
  localparam int ADDR_W = BLK_W + PAGE_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic [3:0]        reqKey,
  input  logic [1:0]        reqClass,
  input  logic              reqOvrStor,
  input  logic              reqOvrFetch,
  input  logic              reqTranslated,
  input  logic              reqPrivate,
  input  logic              keyWrEn,
  output logic [BLK_W-1:0]  lookupBlk,
  input  skg_key_t          lookupKey,
  output skg_upd_t          upd,
  output logic              rspValid,
  output logic              rspPermit,
  output logic              rspOpExc,
  output logic              rspIfetchSup,
  output logic              rspChanChk,
  output logic              rspMeasChk
);
  logic              pendValid, pendStore, pendOvrStor, pendOvrFetch;
  logic              pendTranslated, pendPrivate;
  logic [ADDR_W-1:0] pendAddr;
  logic [3:0]        pendKey;
  skg_class_t        pendClass;
  logic              take;

  assign reqReady = !keyWrEn;
  assign take     = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid      <= 1'b0;
      pendAddr       <= '0;
      pendStore      <= 1'b0;
      pendKey        <= '0;
      pendClass      <= CLS_OPER;
      pendOvrStor    <= 1'b0;
      pendOvrFetch   <= 1'b0;
      pendTranslated <= 1'b0;
      pendPrivate    <= 1'b0;
    end else begin
      pendValid <= take;
      if (take) begin
        pendAddr       <= reqAddr;
        pendStore      <= reqStore;
        pendKey        <= reqKey;
        pendClass      <= skg_class_t'(reqClass);
        pendOvrStor    <= reqOvrStor;
        pendOvrFetch   <= reqOvrFetch;
        pendTranslated <= reqTranslated;
        pendPrivate    <= reqPrivate;
      end
    end
  end

  logic keyHit, procCls, storOvr, lowZone, fetchOvr, checked, allow, deny;

  assign lookupBlk = pendAddr[ADDR_W-1 -: BLK_W];

  always_comb begin
    keyHit   = (pendKey == lookupKey.acc) || (pendKey == 4'd0);
    procCls  = (pendClass == CLS_OPER) || (pendClass == CLS_IFETCH);
    storOvr  = pendOvrStor && procCls && (lookupKey.acc == BYPASS_ACC);
    lowZone  = pendAddr < ADDR_W'(LOW_LIMIT);
    fetchOvr = !pendStore && pendOvrFetch && lowZone
               && !(pendTranslated && pendPrivate) && (pendClass != CLS_MEAS);
    checked  = pendStore || lookupKey.fetchProt;
    allow    = !checked || keyHit || storOvr || fetchOvr;
    deny     = pendValid && !allow;
  end

  assign rspValid     = pendValid;
  assign rspPermit    = pendValid && allow;
  assign rspOpExc     = deny && (pendClass == CLS_OPER);
  assign rspIfetchSup = deny && (pendClass == CLS_IFETCH);
  assign rspChanChk   = deny && (pendClass == CLS_CHAN);
  assign rspMeasChk   = deny && (pendClass == CLS_MEAS);

  assign upd.touch = pendValid && allow;
  assign upd.dirty = pendStore;
endmodule

// File: rtl/stor_key_guard.sv
module stor_key_guard
  import skg_pkg::*;
#(
  parameter int BLK_CNT   = 256,
  parameter int PAGE_LOG2 = 12,
  parameter int LOW_LIMIT = 2048,
  localparam int BLK_W  = $clog2(BLK_CNT),
  localparam int ADDR_W = BLK_W + PAGE_LOG2,
  localparam int KEY_W  = $bits(skg_key_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqStore,
  input  logic [3:0]        reqKey,
  input  logic [1:0]        reqClass,
  input  logic              reqOvrStor,
  input  logic              reqOvrFetch,
  input  logic              reqTranslated,
  input  logic              reqPrivate,
  output logic              rspValid,
  output logic              rspPermit,
  output logic              rspOpExc,
  output logic              rspIfetchSup,
  output logic              rspChanChk,
  output logic              rspMeasChk,
  input  logic              keyWrEn,
  input  logic [BLK_W-1:0]  keyAddr,
  input  logic [KEY_W-1:0]  keyWrData,
  output logic [KEY_W-1:0]  keyRdData
);
  logic [BLK_W-1:0] lookupBlk;
  skg_key_t         lookupKey, rdKey;
  skg_upd_t         upd;

  skg_ctrl #(.BLK_W(BLK_W), .PAGE_LOG2(PAGE_LOG2), .LOW_LIMIT(LOW_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqStore(reqStore), .reqKey(reqKey), .reqClass(reqClass),
    .reqOvrStor(reqOvrStor), .reqOvrFetch(reqOvrFetch),
    .reqTranslated(reqTranslated), .reqPrivate(reqPrivate),
    .keyWrEn(keyWrEn), .lookupBlk(lookupBlk), .lookupKey(lookupKey), .upd(upd),
    .rspValid(rspValid), .rspPermit(rspPermit), .rspOpExc(rspOpExc),
    .rspIfetchSup(rspIfetchSup), .rspChanChk(rspChanChk), .rspMeasChk(rspMeasChk)
  );

  skg_keyarray #(.BLK_CNT(BLK_CNT)) u_keys (
    .clk(clk), .rstN(rstN),
    .keyWrEn(keyWrEn), .keyAddr(keyAddr), .keyWrData(skg_key_t'(keyWrData)),
    .keyRdData(rdKey), .lookupBlk(lookupBlk), .lookupKey(lookupKey), .upd(upd)
  );

  assign keyRdData = rdKey;
endmodule

// File: rtl/skg_chk.sv
module skg_chk #(
  parameter int BLK_W = 8,
  parameter int KEY_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rspValid,
  input logic             rspPermit,
  input logic             rspOpExc,
  input logic             rspIfetchSup,
  input logic             rspChanChk,
  input logic             rspMeasChk,
  input logic             keyWrEn,
  input logic [BLK_W-1:0] keyAddr,
  input logic [KEY_W-1:0] keyWrData,
  input logic [KEY_W-1:0] keyRdData
);
  logic [3:0] flags;
  assign flags = {rspOpExc, rspIfetchSup, rspChanChk, rspMeasChk};

  // R2
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);
  // R2
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));
  // R2
  ready_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyWrEn |-> !reqReady);
  // R7
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(flags));
  // R7
  flag_on_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|flags) |-> (rspValid && !rspPermit));
  // R7
  deny_has_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspPermit) |-> (|flags));
  // R9
  key_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && rstN) |=> (!$stable(keyAddr) || keyRdData == $past(keyWrData)));
  // R8
  ref_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(keyAddr) && !$past(keyWrEn) && $past(keyRdData[1])) |-> keyRdData[1]);
endmodule

bind stor_key_guard skg_chk #(.BLK_W(BLK_W), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspPermit(rspPermit), .rspOpExc(rspOpExc),
  .rspIfetchSup(rspIfetchSup), .rspChanChk(rspChanChk), .rspMeasChk(rspMeasChk),
  .keyWrEn(keyWrEn), .keyAddr(keyAddr), .keyWrData(keyWrData), .keyRdData(keyRdData)
);

// File: tb/stor_key_guard_bench.sv
`timescale 1ns/1ps
module stor_key_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [19:0] reqAddr = '0;
  logic        reqStore = 1'b0;
  logic [3:0]  reqKey = '0;
  logic [1:0]  reqClass = '0;
  logic        reqOvrStor = 1'b0, reqOvrFetch = 1'b0;
  logic        reqTranslated = 1'b0, reqPrivate = 1'b0;
  logic        rspValid, rspPermit, rspOpExc, rspIfetchSup, rspChanChk, rspMeasChk;
  logic        keyWrEn = 1'b0;
  logic [7:0]  keyAddr = '0;
  logic [6:0]  keyWrData = '0;
  logic [6:0]  keyRdData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  stor_key_guard u_stor_key_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqStore(reqStore), .reqKey(reqKey), .reqClass(reqClass),
    .reqOvrStor(reqOvrStor), .reqOvrFetch(reqOvrFetch),
    .reqTranslated(reqTranslated), .reqPrivate(reqPrivate),
    .rspValid(rspValid), .rspPermit(rspPermit), .rspOpExc(rspOpExc),
    .rspIfetchSup(rspIfetchSup), .rspChanChk(rspChanChk), .rspMeasChk(rspMeasChk),
    .keyWrEn(keyWrEn), .keyAddr(keyAddr), .keyWrData(keyWrData), .keyRdData(keyRdData)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected decision built from R3..R6
  function automatic bit expPermit(int acc, int fp, int key, int st, int cls,
                                   int ovS, int ovF, int addr, int tr, int pr);
    bit chk, match, kov, low;
    chk   = (st != 0) || (fp != 0);
    match = (key == acc) || (key == 0);
    kov   = (ovS != 0) && (cls < 2) && (acc == 9);
    low   = (st == 0) && (ovF != 0) && (addr < 2048) && !(tr != 0 && pr != 0) && (cls != 3);
    return !chk || match || kov || low;
  endfunction

  task automatic writeKey(input int blk, input int val);
    @(negedge clk);
    keyWrEn = 1'b1; keyAddr = 8'(blk); keyWrData = 7'(val);
    @(negedge clk);
    keyWrEn = 1'b0;
  endtask

  // Drives one access, checks response (R7) and key bookkeeping (R8)
  task automatic access(input int blk, input int addr, input int acc, input int fp,
                        input int key, input int st, input int cls, input int ovS,
                        input int ovF, input int tr, input int pr, input string tag);
    bit p;
    int flagsExp, flagsAct;
    p = expPermit(acc, fp, key, st, cls, ovS, ovF, addr, tr, pr);
    writeKey(blk, (acc << 3) | (fp << 2));
    reqValid = 1'b1; reqAddr = 20'(addr); reqStore = st[0]; reqKey = 4'(key);
    reqClass = 2'(cls); reqOvrStor = ovS[0]; reqOvrFetch = ovF[0];
    reqTranslated = tr[0]; reqPrivate = pr[0]; keyAddr = 8'(blk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 rspValid", int'(rspValid), 1);
    check(tag, int'(rspPermit), int'(p));
    flagsAct = {rspOpExc, rspIfetchSup, rspChanChk, rspMeasChk};
    flagsExp = p ? 0 : (8 >> cls);
    check("R7 flags", flagsAct, flagsExp);
    @(negedge clk);
    check("R2 rspValid drop", int'(rspValid), 0);
    check("R8 ref/chg", int'(keyRdData), (acc << 3) | (fp << 2) |
          (p ? (2 | (st != 0 ? 1 : 0)) : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rspValid", int'(rspValid), 0);
    check("R1 reqReady", int'(reqReady), 1);
    for (int b = 0; b < 256; b++) begin
      keyAddr = 8'(b);
      #1;
      check("R1 key zero", int'(keyRdData), 0);
    end

    // Main sweep: R3 R4 R5 R7 R8 (addresses above the low zone)
    for (int acc = 0; acc < 16; acc++)
      for (int fp = 0; fp < 2; fp++)
        for (int key = 0; key < 16; key++)
          for (int st = 0; st < 2; st++)
            for (int cls = 0; cls < 4; cls++)
              for (int ovS = 0; ovS < 2; ovS++) begin
                int blk;
                blk = (acc * 16 + key + cls + 1) % 256;
                if (blk == 0) blk = 1;
                access(blk, (blk << 12) | 12'h900, acc, fp, key, st, cls, ovS, 0, 0, 0,
                       "R3 R4 R5 permit");
              end

    // Low-address override boundary: R6
    for (int oi = 0; oi < 5; oi++)
      for (int ovF = 0; ovF < 2; ovF++)
        for (int tr = 0; tr < 2; tr++)
          for (int pr = 0; pr < 2; pr++)
            for (int cls = 0; cls < 4; cls++)
              for (int st = 0; st < 2; st++) begin
                int addr;
                case (oi)
                  0: addr = 0;
                  1: addr = 2047;
                  2: addr = 2048;
                  3: addr = 4095;
                  default: addr = 4096;
                endcase
                access(addr >> 12, addr, 5, 1, 3, st, cls, 0, ovF, tr, pr, "R6 low fetch");
              end

    // R9 collision: permitted store bookkeeping meets key write to same block
    writeKey(7, (4 << 3) | 4);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 20'h07010; reqStore = 1'b1; reqKey = 4'd4;
    reqClass = 2'd0; reqOvrStor = 1'b0; reqOvrFetch = 1'b0;
    @(negedge clk);
    check("R3 collision permit", int'(rspPermit), 1);
    keyWrEn = 1'b1; keyAddr = 8'd7; keyWrData = 7'h50;
    reqAddr = 20'h08000; reqStore = 1'b0;
    #1;
    check("R2 ready low on write", int'(reqReady), 0);
    @(negedge clk);
    keyWrEn = 1'b0; reqValid = 1'b0;
    check("R9 key write wins", int'(keyRdData), 'h50);
    check("R2 no accept during write", int'(rspValid), 0);
    #1;
    check("R9 layout readback", int'(keyRdData[6:3]), 10);

    // R9 all bits written, including ref and change
    writeKey(200, 7'h7F);
    check("R9 full write", int'(keyRdData), 'h7F);
    writeKey(200, 7'h00);
    check("R9 clear write", int'(keyRdData), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule